// File: doc/BRIEF.md
# Single-Line Interrupt Sense Controller

This block watches one asynchronous interrupt pin and turns it into one request line for an upstream interrupt controller. Software chooses how the pin is interpreted (low level, high level, falling edge or rising edge). Qualifying activity is latched in a sticky pending flag. The outgoing request is the pending flag gated by an enable bit.

Software reaches three registers over a plain 32-bit register bus. The bus has a valid strobe, a write flag, an address, write data, read data and a ready signal. Every access finishes in the cycle it is presented. Software clears the pending flag by writing a one to it. A build parameter places the enable register at one of two offsets, so the block can sit in either of two register layouts. There is exactly one source, and there is no source selection.

Top module: `line_irq_sense`

## Requirements
- R1: After reset, the trigger mode, the enable bit and the pending flag all read 0, and `irqOut` is low.
- R2: The trigger mode is bits [1:0] of the register at offset 0x00. The codes are 0 for low level, 1 for falling edge, 2 for high level and 3 for rising edge. The pin passes through a two-flop synchroniser. In an edge mode, only a transition in the selected direction sets pending, and it does so no later than three clock edges after the pin changes.
- R3: In a level mode, pending is set on every cycle that the synchronised pin shows the active level. An acknowledge written while that level is still present leaves pending at 1.
- R4: Pending is bit 0 of the register at offset 0x04. Writing a word with bit 0 = 1 clears it. Writing a word with bit 0 = 0 leaves it unchanged.
- R5: When an acknowledge and a qualifying event fall in the same cycle, pending ends that cycle at 1.
- R6: The enable flag is bit 0 of the register at offset 0x08 when `ENA_AT_34` = 0, and at offset 0x34 when `ENA_AT_34` = 1. `irqOut` is high exactly while pending and enable are both 1. Pending keeps latching events while enable is 0.
- R7: Reads return the register value in bits [1:0] (mode) or bit [0] (pending, enable), with every other bit 0. Any other address reads 0, and a write to it changes nothing. This includes the enable offset that the parameter did not select.
- R8: Rewriting the trigger mode while the pin is steady does not set pending.
- R9: `busReady` is high in the same cycle as `busValid`, so each access takes one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqPin | input | 1 | Asynchronous interrupt pin |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid in the access cycle |
| busReady | output | 1 | Access completes this cycle |
| irqOut | output | 1 | Request to the upstream interrupt controller |

## Verification
The bench builds two copies of the block that share the pin and the bus. The main copy keeps the default `ENA_AT_34` = 0, so the enable register sits at 0x08. It runs the full mode, acknowledge and gating sequence, and it also shows that offset 0x34 is dead in that layout. The second copy is built with `ENA_AT_34` = 1. This brings the alternative layout within reach: enable works at 0x34, while 0x08 reads zero and ignores writes.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;

  // Trigger codes; bit 0 selects edge, bit 1 selects high/rising polarity
  typedef enum logic [1:0] {
    TRIG_LOW_LVL  = 2'd0,
    TRIG_FALL     = 2'd1,
    TRIG_HIGH_LVL = 2'd2,
    TRIG_RISE     = 2'd3
  } trig_e;

  // Strobes from register decode to the datapath
  typedef struct packed {
    logic       wrMode;
    logic       wrEna;
    logic       ackPend;
    logic [1:0] wBits;
  } regStb_t;

  localparam int unsigned OFS_MODE   = 32'h00;
  localparam int unsigned OFS_PEND   = 32'h04;
  localparam int unsigned OFS_ENA_LO = 32'h08;
  localparam int unsigned OFS_ENA_HI = 32'h34;

endpackage

// File: rtl/line_irq_regif.sv
module line_irq_regif
  import line_irq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter bit ENA_AT_34 = 1'b0
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  trig_e             modeQ,
  input  logic              enaQ,
  input  logic              pendQ,
  output regStb_t           stb,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady
);

  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] ENA_ADDR  =
    ENA_AT_34 ? ADDR_W'(OFS_ENA_HI) : ADDR_W'(OFS_ENA_LO);

  logic hitMode, hitPend, hitEna, doWr, doRd;

  always_comb begin
    hitMode = (busAddr == MODE_ADDR);
    hitPend = (busAddr == PEND_ADDR);
    hitEna  = (busAddr == ENA_ADDR);
    doWr    = busValid && busWrite;
    doRd    = busValid && !busWrite;

    stb.wrMode  = doWr && hitMode;
    stb.wrEna   = doWr && hitEna;
    stb.ackPend = doWr && hitPend && busWdata[0];
    stb.wBits   = busWdata[1:0];

    busRdata = '0;
    if (doRd) begin
      if (hitMode)     busRdata[1:0] = modeQ;
      else if (hitPend) busRdata[0]  = pendQ;
      else if (hitEna)  busRdata[0]  = enaQ;
    end
  end

  assign busReady = busValid;

endmodule

// File: rtl/line_irq_sense_dp.sv
module line_irq_sense_dp
  import line_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    irqPin,
  input  regStb_t stb,
  output trig_e   modeQ,
  output logic    enaQ,
  output logic    pendQ,
  output logic    evt,
  output logic    irqOut
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic pinNow, prevQ;

  // Synchroniser chain, idle-high so the default low-level mode starts quiet
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)   syncQ[s] <= 1'b1;
      else if (s == 0) syncQ[s] <= irqPin;
      else         syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end

  assign pinNow = syncQ[SYNC_STAGES-1];

  // Reference sample, reloaded every cycle (mode writes included)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= pinNow;
  end

  always_comb begin
    unique case (modeQ)
      TRIG_LOW_LVL:  evt = !pinNow;
      TRIG_FALL:     evt = prevQ && !pinNow;
      TRIG_HIGH_LVL: evt = pinNow;
      TRIG_RISE:     evt = !prevQ && pinNow;
      default:       evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= TRIG_LOW_LVL;
      enaQ  <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      if (stb.wrMode) modeQ <= trig_e'(stb.wBits);
      if (stb.wrEna)  enaQ  <= stb.wBits[0];
      pendQ <= evt || (pendQ && !stb.ackPend);
    end
  end

  assign irqOut = pendQ && enaQ;

endmodule

// File: rtl/line_irq_sense.sv
module line_irq_sense
  import line_irq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter bit ENA_AT_34   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqPin,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady,
  output logic              irqOut
);

  regStb_t regStb;
  trig_e   modeQ;
  logic    enaQ, pendQ, dpEvt;

  line_irq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENA_AT_34(ENA_AT_34)) u_regif (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .modeQ(modeQ), .enaQ(enaQ), .pendQ(pendQ),
    .stb(regStb), .busRdata(busRdata), .busReady(busReady)
  );

  line_irq_sense_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .irqPin(irqPin), .stb(regStb),
    .modeQ(modeQ), .enaQ(enaQ), .pendQ(pendQ), .evt(dpEvt), .irqOut(irqOut)
  );

endmodule

// File: rtl/line_irq_sense_chk.sv
module line_irq_sense_chk
  import line_irq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter bit ENA_AT_34 = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqOut,
  input logic              pendQ,
  input logic              evtQ,
  input regStb_t           stb
);

  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] ENA_A  =
    ENA_AT_34 ? ADDR_W'(OFS_ENA_HI) : ADDR_W'(OFS_ENA_LO);

  logic unmappedRd;
  assign unmappedRd = busValid && !busWrite &&
                      busAddr != PEND_A && busAddr != MODE_A && busAddr != ENA_A;

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackPend && !evtQ) |=> !pendQ);

  assert_zero_write_keeps_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == PEND_A && !busWdata[0] && pendQ) |=> pendQ);

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    evtQ |=> pendQ);

  assert_disable_drops_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == ENA_A && !busWdata[0]) |=> !irqOut);

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:2] == '0);

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    unmappedRd |-> busRdata == '0);

endmodule

bind line_irq_sense line_irq_sense_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENA_AT_34(ENA_AT_34)
) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .irqOut(irqOut), .pendQ(pendQ), .evtQ(dpEvt), .stb(regStb)
);

// File: tb/line_irq_sense_bench.sv
module line_irq_sense_bench;

  typedef struct packed {
    logic        pin;
    logic        doWr;
    logic [7:0]  wAddr;
    logic [31:0] wData;
    logic [7:0]  rAddr;
    logic [31:0] expRd;
    logic        expIrq;
  } vec_t;

  // Main copy: enable at 0x08. Per-row requirement tags in comments.
  localparam int NVEC = 21;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b1, 8'h00, 32'h3,        8'h04, 32'h0, 1'b0}, // R8 rise mode, pin steady
    '{1'b1, 1'b1, 8'h08, 32'h1,        8'h08, 32'h1, 1'b0}, // R6 enable on
    '{1'b0, 1'b0, 8'h00, 32'h0,        8'h04, 32'h0, 1'b0}, // R2 falling ignored in rise mode
    '{1'b1, 1'b0, 8'h00, 32'h0,        8'h04, 32'h1, 1'b1}, // R2 rising sets
    '{1'b1, 1'b1, 8'h04, 32'hFFFFFFFE, 8'h04, 32'h1, 1'b1}, // R4 write zero no effect
    '{1'b1, 1'b1, 8'h04, 32'h1,        8'h04, 32'h0, 1'b0}, // R4 ack clears
    '{1'b1, 1'b1, 8'h08, 32'hFFFFFFFE, 8'h08, 32'h0, 1'b0}, // R6 disable
    '{1'b0, 1'b1, 8'h00, 32'h1,        8'h04, 32'h1, 1'b0}, // R6 latch while disabled, R2 fall
    '{1'b0, 1'b1, 8'h08, 32'h1,        8'h04, 32'h1, 1'b1}, // R6 gate opens
    '{1'b0, 1'b1, 8'h00, 32'h0,        8'h00, 32'h0, 1'b1}, // R2 low level readback
    '{1'b0, 1'b1, 8'h04, 32'h1,        8'h04, 32'h1, 1'b1}, // R3 ack while low level
    '{1'b1, 1'b0, 8'h00, 32'h0,        8'h04, 32'h1, 1'b1}, // R3 stays latched
    '{1'b1, 1'b1, 8'h04, 32'h1,        8'h04, 32'h0, 1'b0}, // R4 ack clears
    '{1'b1, 1'b1, 8'h00, 32'h2,        8'h04, 32'h1, 1'b1}, // R3 high level sets
    '{1'b0, 1'b1, 8'h04, 32'h1,        8'h04, 32'h1, 1'b1}, // R3 ack while level still synced
    '{1'b0, 1'b1, 8'h04, 32'h1,        8'h04, 32'h0, 1'b0}, // R3 level gone, ack clears
    '{1'b0, 1'b1, 8'h34, 32'h0,        8'h08, 32'h1, 1'b0}, // R7 write to 0x34 ignored
    '{1'b0, 1'b0, 8'h00, 32'h0,        8'h34, 32'h0, 1'b0}, // R7 0x34 reads zero
    '{1'b0, 1'b0, 8'h00, 32'h0,        8'h0C, 32'h0, 1'b0}, // R7 unmapped reads zero
    '{1'b0, 1'b1, 8'h00, 32'hFFFFFFFF, 8'h00, 32'h3, 1'b0}, // R7 upper bits zero
    '{1'b1, 1'b0, 8'h00, 32'h0,        8'h04, 32'h1, 1'b1}  // R2 rise after mode write
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irqPin = 1'b1;
  logic        busValid = 1'b0, altValid = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, altRdata;
  logic        busReady, altReady, irqOut, altIrq;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  line_irq_sense u_line_irq_sense (
    .clk(clk), .rstN(rstN), .irqPin(irqPin), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady),
    .irqOut(irqOut)
  );

  line_irq_sense #(.ENA_AT_34(1'b1)) u_alt (
    .clk(clk), .rstN(rstN), .irqPin(irqPin), .busValid(altValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(altRdata), .busReady(altReady),
    .irqOut(altIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit alt, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    if (alt) altValid = 1'b1; else busValid = 1'b1;
    @(negedge clk);
    busValid = 1'b0; altValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input bit alt, input logic [7:0] a, output logic [31:0] d);
    busWrite = 1'b0; busAddr = a;
    if (alt) altValid = 1'b1; else busValid = 1'b1;
    #1;
    d = alt ? altRdata : busRdata;
    busValid = 1'b0; altValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(0, 8'h00, r); check("R1 mode", r, 32'h0);
    rd(0, 8'h04, r); check("R1 pending", r, 32'h0);
    rd(0, 8'h08, r); check("R1 enable", r, 32'h0);
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);

    // R9 ready in access cycle
    busValid = 1'b1; busAddr = 8'h00; #1;
    check("R9 ready high", {31'b0, busReady}, 32'h1);
    busValid = 1'b0; #1;
    check("R9 ready low", {31'b0, busReady}, 32'h0);

    // Vector walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      irqPin = VEC[i].pin;
      if (VEC[i].doWr) begin
        busValid = 1'b1; busWrite = 1'b1;
        busAddr = VEC[i].wAddr; busWdata = VEC[i].wData;
      end
      @(negedge clk);
      busValid = 1'b0; busWrite = 1'b0;
      repeat (3) @(negedge clk);
      rd(0, VEC[i].rAddr, r);
      check($sformatf("vec%0d read", i), r, VEC[i].expRd);
      check($sformatf("vec%0d irq", i), {31'b0, irqOut}, {31'b0, VEC[i].expIrq});
    end

    // R5 ack and rising edge in the same cycle (mode rise, pin high, pend 1)
    wr(0, 8'h04, 32'h1);
    @(negedge clk); irqPin = 1'b0;
    repeat (4) @(negedge clk);
    rd(0, 8'h04, r); check("R5 precondition clear", r, 32'h0);
    irqPin = 1'b1;               // before edge k
    @(negedge clk);              // after k
    @(negedge clk);              // after k+1
    busValid = 1'b1; busWrite = 1'b1; busAddr = 8'h04; busWdata = 32'h1;
    @(negedge clk);              // after k+2: event and ack together
    busValid = 1'b0; busWrite = 1'b0;
    rd(0, 8'h04, r); check("R5 event beats ack", r, 32'h1);
    check("R5 irq", {31'b0, irqOut}, 32'h1);

    // R6/R7 alternative layout: enable at 0x34, 0x08 dead
    wr(1, 8'h08, 32'h1);
    @(negedge clk);
    rd(1, 8'h08, r); check("R7 alt 0x08 reads zero", r, 32'h0);
    rd(1, 8'h34, r); check("R7 alt write 0x08 ignored", r, 32'h0);
    wr(1, 8'h34, 32'h1);
    @(negedge clk);
    rd(1, 8'h34, r); check("R6 alt enable at 0x34", r, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule